// File: doc/BRIEF.md
# Video Line-Fetch DMA Engine

This block is a read-only bus master that keeps a display line buffer supplied from a frame buffer in system memory. A display timing generator drives two flags. One is high while a line is being shown and the other is high while the visible part of a frame is being shown. Each time a visible line ends inside an active frame, the engine requests the bus and reads the next stored line. It uses locked, incrementing AHB bursts of unspecified length with 32-bit beats, and it writes every returned word into the line buffer at consecutive word addresses starting from zero.

Each 32-bit word holds two 16-bit pixels, so a line of P pixels takes P/2 beats. The engine never lets a burst run past a 1 KB address boundary. It ends the burst on the last word before the boundary, drops the request, and then starts a fresh burst at the next address. The engine counts finished lines. Once the configured number has been fetched, it raises a frame interrupt and ignores further line ends until the frame flag falls. At that point the read pointer is reloaded from the base address and the line count is cleared. Writing a new base address clears the interrupt. The new base only takes effect at the next frame boundary, or at once while the engine is disabled.

When pixels are doubled, the timing generator signals a line end only once per repeated pair of display lines. The engine therefore needs no mode input: it fetches the configured number of stored lines of the configured width. The line-buffer write port has no back-pressure. Flow control comes only from the AHB `hready` wait states, and a word is written in the cycle its data phase completes.

Top module: `vline_fetch_dma`

## Requirements
- R1: After reset, `hbusreq`, `hlock`, `lb_we` and `frame_irq` are 0, `htrans` is IDLE (2'b00) and `cur_addr` is 0.
- R2: While `cfg_en` is 0, no bus request is made and nothing is written to the line buffer, whatever the timing flags do.
- R3: With `cfg_en` high, a line count below `cfg_lines`, and `frame_act` high, a 1-to-0 change of `line_act` causes `hbusreq` and `hlock` to be high in the next cycle.
- R4: `hburst` is always INCR (3'b001) and `hsize` is always word (3'b010). The first beat after each grant is NONSEQ (2'b10), and the later beats of that burst are SEQ (2'b11) at addresses that each increase by 4.
- R5: A beat whose address has bits [9:0] equal to 0x3FC is the last beat of its burst. The next beat is NONSEQ at that address plus 4, issued after a new request.
- R6: A line takes `cfg_pixels`/2 beats. The word read at the k-th beat is written to line-buffer address k (counting from 0), and `lb_wdata` is the `hrdata` of that beat.
- R7: While `hready` is 0, the address phase holds its `haddr` and `htrans`, and no line-buffer write happens. No beat is lost or repeated.
- R8: After `cfg_lines` lines have been fetched, `frame_irq` rises and no further fetch starts until `frame_act` falls.
- R9: `frame_irq` stays high until a cycle with `cfg_base_wr` high, after which it reads 0.
- R10: `cur_addr` is the next address to be read. It follows `cfg_base` while disabled, keeps running across the lines of a frame, and is reloaded from `cfg_base` when `frame_act` falls.
- R11: With `cfg_lines` equal to 0 or `cfg_pixels` below 2, a line end starts no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Engine enable |
| cfg_base | input | 32 | Frame buffer base byte address |
| cfg_base_wr | input | 1 | One-cycle strobe: a new base was written (clears interrupt) |
| cfg_lines | input | 16 | Lines fetched per frame |
| cfg_pixels | input | 16 | Pixels per stored line |
| line_act | input | 1 | High while a display line is active |
| frame_act | input | 1 | High while the visible frame is active |
| hgrant | input | 1 | AHB bus grant |
| hready | input | 1 | AHB transfer ready |
| hrdata | input | 32 | AHB read data |
| hbusreq | output | 1 | AHB bus request |
| hlock | output | 1 | AHB locked transfer request |
| haddr | output | 32 | AHB address |
| htrans | output | 2 | AHB transfer type |
| hburst | output | 3 | AHB burst type (INCR) |
| hsize | output | 3 | AHB transfer size (word) |
| lb_we | output | 1 | Line-buffer write enable |
| lb_waddr | output | 9 | Line-buffer word address |
| lb_wdata | output | 32 | Line-buffer write data |
| cur_addr | output | 32 | Next memory address to be read |
| frame_irq | output | 1 | Frame-complete interrupt |

## Verification
The bench starts a line 32 bytes below a 1 KB boundary and another line 16 bytes below one. A design that ignored the boundary would keep emitting SEQ beats across it, and one that split in the wrong place would show a NONSEQ at the wrong beat or lose a word. Random wait states and a delayed grant are applied to a whole frame to catch beats that are duplicated, dropped, or written while `hready` is low. The frame-end path is also covered. An extra line end after the last line must not fetch, the interrupt must hold until a base write, and the base must not be applied until the frame flag falls. A design that reloaded the base too early, or kept counting lines across frames, would read from the wrong addresses. Zero lines and a one-pixel width check that degenerate settings do not leave the engine stuck on the bus.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  typedef enum logic [1:0] {C_IDLE, C_BEGIN, C_XMIT, C_WAIT} ctrl_st_t;
  typedef enum logic [1:0] {T_IDLE, T_REQ, T_BUSY, T_DRAIN} xfer_st_t;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;
  localparam logic [2:0] HB_INCR   = 3'b001;
  localparam logic [2:0] HS_WORD   = 3'b010;
endpackage

// File: rtl/vlf_ctrl.sv
module vlf_ctrl
  import vlf_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BEAT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [CNT_W-1:0]  cfg_lines,
  input  logic [BEAT_W-1:0] line_beats,
  input  logic              cfg_base_wr,
  input  logic              line_act,
  input  logic              frame_act,
  input  logic              xf_own,
  input  logic              xf_done,
  output logic              xf_start,
  output logic              addr_load,
  output logic              frame_irq
);
  ctrl_st_t         st, st_n;
  logic             la_q, fa_q;
  logic [CNT_W-1:0] line_cnt;
  logic             line_fall, frame_fall, trig, last_line, rearm, line_end;

  assign line_fall  = la_q & ~line_act;
  assign frame_fall = fa_q & ~frame_act;
  assign trig       = cfg_en && frame_act && line_fall &&
                      (line_cnt < cfg_lines) && (line_beats != '0);
  assign last_line  = (line_cnt + CNT_W'(1)) == cfg_lines;
  assign rearm      = ((st == C_IDLE) || (st == C_WAIT)) && (!cfg_en || frame_fall);
  assign line_end   = (st == C_XMIT) && xf_done;
  assign xf_start   = (st == C_IDLE) && !rearm && trig;
  assign addr_load  = rearm;

  always_comb begin
    st_n = st;
    unique case (st)
      C_IDLE:  if (!rearm && trig) st_n = C_BEGIN;
      C_BEGIN: if (xf_own) st_n = C_XMIT;
      C_XMIT:  if (xf_done) st_n = last_line ? C_WAIT : C_IDLE;
      C_WAIT:  if (rearm) st_n = C_IDLE;
      default: st_n = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= C_IDLE;
      la_q      <= 1'b0;
      fa_q      <= 1'b0;
      line_cnt  <= '0;
      frame_irq <= 1'b0;
    end else begin
      st   <= st_n;
      la_q <= line_act;
      fa_q <= frame_act;
      if (rearm)         line_cnt <= '0;
      else if (line_end) line_cnt <= line_cnt + CNT_W'(1);
      if (line_end && last_line) frame_irq <= 1'b1;
      else if (cfg_base_wr)      frame_irq <= 1'b0;
    end
  end

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_irq && !cfg_base_wr) |=> frame_irq);
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> ($past(st) == C_XMIT));
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && st == C_IDLE) |=> (st == C_IDLE));
endmodule

// File: rtl/vlf_ahb_rd.sv
module vlf_ahb_rd
  import vlf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BEAT_W      = 15,
  parameter int BOUND_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xf_start,
  input  logic [BEAT_W-1:0] line_beats,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              hgrant,
  input  logic              hready,
  output logic              hbusreq,
  output logic              hlock,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              xf_own,
  output logic              xf_done,
  output logic              beat_we,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int STEP = DATA_W / 8;
  localparam int BB   = $clog2(BOUND_BYTES);
  localparam logic [BB-1:0] LAST_OFS = BB'(BOUND_BYTES - STEP);

  xfer_st_t          st;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] left_q;
  logic              dph_q, first_q, at_edge, last_issue;

  assign at_edge    = addr_q[BB-1:0] == LAST_OFS;
  assign last_issue = left_q == BEAT_W'(1);
  assign xf_own     = (st == T_REQ) && hgrant && hready;
  assign beat_we    = dph_q && hready;
  assign xf_done    = (st == T_DRAIN) && hready && dph_q && (left_q == '0);
  assign hbusreq    = (st == T_REQ) || (st == T_BUSY);
  assign hlock      = hbusreq;
  assign htrans     = (st != T_BUSY) ? HT_IDLE : (first_q ? HT_NONSEQ : HT_SEQ);
  assign haddr      = addr_q;
  assign rd_addr    = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= T_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      dph_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (beat_we) dph_q <= 1'b0;
      unique case (st)
        T_IDLE: begin
          if (addr_load) addr_q <= load_addr;
          else if (xf_start) begin
            st     <= T_REQ;
            left_q <= line_beats;
          end
        end
        T_REQ: begin
          if (xf_own) begin
            st      <= T_BUSY;
            first_q <= 1'b1;
          end
        end
        T_BUSY: begin
          if (hready) begin
            dph_q   <= 1'b1;
            addr_q  <= addr_q + ADDR_W'(STEP);
            left_q  <= left_q - BEAT_W'(1);
            first_q <= 1'b0;
            if (last_issue || at_edge) st <= T_DRAIN;
          end
        end
        T_DRAIN: begin
          if (hready && dph_q) st <= (left_q == '0) ? T_IDLE : T_REQ;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  p_hold_on_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != HT_IDLE && !hready) |=> (htrans == $past(htrans) && haddr == $past(haddr)));
  p_split_at_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != HT_IDLE && hready && haddr[BB-1:0] == LAST_OFS) |=> (htrans == HT_IDLE));
  p_grant_nonseq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xf_own |=> (htrans == HT_NONSEQ));
  p_load_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> (st == T_IDLE));
  p_no_beat_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_IDLE) |-> !beat_we);
endmodule

// File: rtl/vlf_lbuf_wr.sv
module vlf_lbuf_wr #(
  parameter int LB_AW  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              beat_we,
  input  logic [DATA_W-1:0] rd_data,
  output logic              lb_we,
  output logic [LB_AW-1:0]  lb_waddr,
  output logic [DATA_W-1:0] lb_wdata
);
  logic [LB_AW-1:0] wptr;

  always_ff @(posedge clk) begin
    if (!rst_n)          wptr <= '0;
    else if (line_start) wptr <= '0;
    else if (beat_we)    wptr <= wptr + LB_AW'(1);
  end

  assign lb_we    = beat_we;
  assign lb_waddr = wptr;
  assign lb_wdata = rd_data;

  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (lb_waddr == '0 && !lb_we));
endmodule

// File: rtl/vline_fetch_dma.sv
module vline_fetch_dma
  import vlf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int PIX_W       = 16,
  parameter int LB_AW       = 9,
  parameter int BOUND_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_base_wr,
  input  logic [CNT_W-1:0]  cfg_lines,
  input  logic [PIX_W-1:0]  cfg_pixels,
  input  logic              line_act,
  input  logic              frame_act,
  input  logic              hgrant,
  input  logic              hready,
  input  logic [DATA_W-1:0] hrdata,
  output logic              hbusreq,
  output logic              hlock,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic              lb_we,
  output logic [LB_AW-1:0]  lb_waddr,
  output logic [DATA_W-1:0] lb_wdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              frame_irq
);
  localparam int BEAT_W = PIX_W - 1;

  logic [BEAT_W-1:0] line_beats;
  logic xf_start, xf_own, xf_done, addr_load, beat_we;

  assign line_beats = BEAT_W'(cfg_pixels >> 1);
  assign hburst     = HB_INCR;
  assign hsize      = HS_WORD;

  vlf_ctrl #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_lines(cfg_lines),
    .line_beats(line_beats), .cfg_base_wr(cfg_base_wr), .line_act(line_act),
    .frame_act(frame_act), .xf_own(xf_own), .xf_done(xf_done),
    .xf_start(xf_start), .addr_load(addr_load), .frame_irq(frame_irq)
  );

  vlf_ahb_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W),
               .BOUND_BYTES(BOUND_BYTES)) u_xfer (
    .clk(clk), .rst_n(rst_n), .xf_start(xf_start), .line_beats(line_beats),
    .addr_load(addr_load), .load_addr(cfg_base), .hgrant(hgrant), .hready(hready),
    .hbusreq(hbusreq), .hlock(hlock), .haddr(haddr), .htrans(htrans),
    .xf_own(xf_own), .xf_done(xf_done), .beat_we(beat_we), .rd_addr(cur_addr)
  );

  vlf_lbuf_wr #(.LB_AW(LB_AW), .DATA_W(DATA_W)) u_lbuf (
    .clk(clk), .rst_n(rst_n), .line_start(xf_start), .beat_we(beat_we),
    .rd_data(hrdata), .lb_we(lb_we), .lb_waddr(lb_waddr), .lb_wdata(lb_wdata)
  );
endmodule

// File: tb/vline_fetch_dma_test.sv
module vline_fetch_dma_test;
  localparam int LB_AW = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_en, cfg_base_wr, line_act, frame_act;
  logic [31:0] cfg_base;
  logic [15:0] cfg_lines, cfg_pixels;
  logic hgrant = 1'b0, hready = 1'b1;
  logic [31:0] hrdata;
  logic hbusreq, hlock, lb_we, frame_irq;
  logic [31:0] haddr, lb_wdata, cur_addr;
  logic [1:0] htrans;
  logic [2:0] hburst, hsize;
  logic [LB_AW-1:0] lb_waddr;

  vline_fetch_dma uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_base_wr(cfg_base_wr), .cfg_lines(cfg_lines), .cfg_pixels(cfg_pixels),
    .line_act(line_act), .frame_act(frame_act), .hgrant(hgrant), .hready(hready),
    .hrdata(hrdata), .hbusreq(hbusreq), .hlock(hlock), .haddr(haddr),
    .htrans(htrans), .hburst(hburst), .hsize(hsize), .lb_we(lb_we),
    .lb_waddr(lb_waddr), .lb_wdata(lb_wdata), .cur_addr(cur_addr),
    .frame_irq(frame_irq)
  );

  int checks = 0, fails = 0;

  typedef struct { logic [31:0] a; logic ns; } ad_t;
  typedef struct { logic [LB_AW-1:0] w; logic [31:0] d; } wr_t;
  ad_t ad_q[$];
  wr_t wr_q[$];

  function automatic logic [31:0] memw(input logic [31:0] a);
    return {a[15:0] ^ 16'h6B1D, ~a[15:0]} ^ 32'h00F0_3C00;
  endfunction

  // memory slave model
  logic [31:0] dp_addr = '0;
  logic [7:0]  lfsr = 8'h5D;
  logic        stall_en = 1'b0;
  int          gdelay = 0, gcnt = 0;
  always @(posedge clk) if (hready && htrans[1]) dp_addr <= haddr;
  assign hrdata = memw(dp_addr);
  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    hready <= stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    gcnt   <= hbusreq ? gcnt + 1 : 0;
    hgrant <= hbusreq && (gcnt >= gdelay);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compares bus beats and line-buffer writes against the scoreboard
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (htrans != 2'b00 && hready) begin
        checks++;
        if (ad_q.size() == 0) begin
          fails++;
          $display("FAIL R4 unexpected beat act=%h exp=none", haddr);
        end else begin
          ad_t e;
          e = ad_q.pop_front();
          if (haddr !== e.a || htrans !== (e.ns ? 2'b10 : 2'b11)) begin
            fails++;
            $display("FAIL R5 beat act=%h/%b exp=%h/%b", haddr, htrans, e.a, e.ns ? 2'b10 : 2'b11);
          end
        end
      end
      if (lb_we) begin
        checks++;
        if (!hready) begin
          fails++;
          $display("FAIL R7 write during wait act=%b exp=1", hready);
        end else if (wr_q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected write act=%h exp=none", lb_wdata);
        end else begin
          wr_t y;
          y = wr_q.pop_front();
          if (lb_waddr !== y.w || lb_wdata !== y.d) begin
            fails++;
            $display("FAIL R6 write act=%h:%h exp=%h:%h", lb_waddr, lb_wdata, y.w, y.d);
          end
        end
      end
    end
  end

  task automatic queue_line(input logic [31:0] a0, input int beats);
    for (int k = 0; k < beats; k++) begin
      ad_t x;
      wr_t y;
      x.a  = a0 + 32'(4 * k);
      x.ns = (k == 0) || (((x.a - 32'd4) & 32'h3FF) == 32'h3FC);
      y.w  = LB_AW'(k);
      y.d  = memw(x.a);
      ad_q.push_back(x);
      wr_q.push_back(y);
    end
  endtask

  task automatic do_line(input bit fetch, input logic [31:0] a0, input int beats, input string tag);
    @(negedge clk);
    line_act = 1'b1;
    repeat (3) @(negedge clk);
    if (fetch) queue_line(a0, beats);
    line_act = 1'b0;
    @(negedge clk);
    if (fetch) begin
      int n = 0;
      chk(hbusreq && hlock, "R3 request after line end", {30'd0, hbusreq, hlock}, 32'd3);
      while ((wr_q.size() != 0 || hbusreq || htrans != 2'b00) && n < 3000) begin
        @(negedge clk);
        n++;
      end
      chk(wr_q.size() == 0 && ad_q.size() == 0, "R6 line fully fetched", 32'(wr_q.size()), 32'd0);
      repeat (2) @(negedge clk);
    end else begin
      bit seen = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (hbusreq || htrans != 2'b00) seen = 1'b1;
      end
      chk(!seen, tag, {31'd0, seen}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_base = '0; cfg_base_wr = 1'b0;
    cfg_lines = '0; cfg_pixels = '0; line_act = 1'b0; frame_act = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({hbusreq, hlock, htrans, lb_we, frame_irq} == 6'd0 && cur_addr == 32'd0,
        "R1 reset outputs", {hbusreq, hlock, htrans, lb_we, frame_irq, cur_addr[25:0]}, 32'd0);
    chk(hburst == 3'b001 && hsize == 3'b010, "R4 burst attributes", {26'd0, hburst, hsize}, 32'h0A);
    // R2 / R10: disabled engine follows base, never fetches
    cfg_base = 32'h0000_1F00;
    repeat (2) @(negedge clk);
    chk(cur_addr == 32'h1F00, "R10 follows base while disabled", cur_addr, 32'h1F00);
    frame_act = 1'b1;
    do_line(1'b0, 0, 0, "R2 no fetch while disabled");
    // frame 1: split at 0x3FC, no stalls
    cfg_base = 32'h0000_03E0; cfg_lines = 16'd3; cfg_pixels = 16'd32;
    repeat (2) @(negedge clk);
    cfg_en = 1'b1;
    @(negedge clk);
    do_line(1'b1, 32'h3E0, 16, "");
    chk(frame_irq == 1'b0, "R8 no early interrupt", {31'd0, frame_irq}, 32'd0);
    do_line(1'b1, 32'h420, 16, "");
    do_line(1'b1, 32'h460, 16, "");
    chk(frame_irq == 1'b1, "R8 interrupt after last line", {31'd0, frame_irq}, 32'd1);
    chk(cur_addr == 32'h4A0, "R10 pointer runs across lines", cur_addr, 32'h4A0);
    do_line(1'b0, 0, 0, "R8 no fetch after frame count");
    chk(frame_irq == 1'b1, "R9 interrupt holds", {31'd0, frame_irq}, 32'd1);
    // R9 clear by base write, R10 base deferred to frame boundary
    cfg_base = 32'h0000_07F0; cfg_base_wr = 1'b1;
    @(negedge clk);
    cfg_base_wr = 1'b0;
    chk(frame_irq == 1'b0, "R9 base write clears interrupt", {31'd0, frame_irq}, 32'd0);
    chk(cur_addr == 32'h4A0, "R10 base not applied mid-frame", cur_addr, 32'h4A0);
    frame_act = 1'b0;
    @(negedge clk);
    chk(cur_addr == 32'h7F0, "R10 reload at frame end", cur_addr, 32'h7F0);
    // frame 2: wait states and delayed grant (R7), split at 0x7FC
    stall_en = 1'b1; gdelay = 2; cfg_lines = 16'd2; cfg_pixels = 16'd40;
    frame_act = 1'b1;
    repeat (2) @(negedge clk);
    do_line(1'b1, 32'h7F0, 20, "");
    do_line(1'b1, 32'h840, 20, "");
    chk(frame_irq == 1'b1, "R8 interrupt after stalled frame", {31'd0, frame_irq}, 32'd1);
    stall_en = 1'b0; gdelay = 0;
    // R11 degenerate settings
    frame_act = 1'b0;
    repeat (2) @(negedge clk);
    frame_act = 1'b1;
    cfg_lines = 16'd0;
    do_line(1'b0, 0, 0, "R11 zero lines");
    cfg_lines = 16'd4; cfg_pixels = 16'd1;
    do_line(1'b0, 0, 0, "R11 sub-word line");
    cfg_pixels = 16'd4;
    do_line(1'b1, 32'h7F0, 2, "");
    chk(cur_addr == 32'h7F8, "R10 pointer after short line", cur_addr, 32'h7F8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule